// File: doc/BRIEF.md
# ADC Result Output Port

This block sits on the digital side of a 16-bit sampling converter. It holds each finished conversion result and presents it to a host. The host reads it either as a parallel word on a 16-pin bus, or as a serial bit stream on pin 0 of that same bus. A single active-low select term gates every output. It is formed by OR-ing the chip select with the read strobe, so the host can use either one as the output enable.

For hosts with an 8-bit data path, the two byte lanes can be exchanged. A byte-swap input tied to an address line then lets a narrow bus fetch both halves from one lane. A coding input chooses straight binary or two's complement for the output word. The converter's raw result is straight binary; two's complement is made by inverting its most significant bit.

Results arrive with a one-cycle valid strobe. A result that lands while a read is under way is parked and shown only after the host deselects, so no read ever sees a word change under it. The serial clock is asynchronous to the block clock. It is synchronised, and the output bit moves on its falling edge.

Top module: `adc_result_port`

## Requirements
- R1: While reset is asserted, and right after it, the bus is undriven: bus_oe is all zero and bus_q is zero. The visible result word resets to 0x0000.
- R2: If cs_n is high or rd_n is high, bus_oe is all zero and bus_q is zero, whatever the other inputs are.
- R3: With both cs_n and rd_n low and ser_mode low, bus_oe is all ones. With swap_bytes low, bus_q[15:8] carries word bits [15:8] and bus_q[7:0] carries word bits [7:0].
- R4: In parallel mode with swap_bytes high, bus_q[15:8] carries word bits [7:0] and bus_q[7:0] carries word bits [15:8]. The byte swap takes effect at once, even in the middle of a read.
- R5: With twos_sel low, the output word equals the raw result. With twos_sel high, the output word equals the raw result with bit 15 inverted.
- R6: A res_valid pulse at clock edge k, with the port deselected at edge k+1, makes res_raw the visible word from edge k+1 onward.
- R7: A result that arrives while the port is selected does not change the output during that read. It becomes visible at the first clock edge at which the port is deselected.
- R8: With the port selected and ser_mode high, bus_oe is 0x0001 and bus_q[15:1] is zero. After k falling serial-clock edges in the current read, bus_q[0] carries word bit 15-k. The bit moves on the third block-clock edge after the serial clock falls.
- R9: Once bit 0 is on the serial pin (after 15 falling edges), further falling edges leave it there until the port is deselected. A new read restarts at bit 15.
- R10: twos_sel is sampled only while the port is deselected. A change during a read has no effect until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| ser_mode | input | 1 | 0 = parallel bus, 1 = serial on pin 0 |
| swap_bytes | input | 1 | 1 exchanges the two byte lanes |
| twos_sel | input | 1 | 1 = two's complement output, 0 = straight binary |
| sclk | input | 1 | Serial clock from host, asynchronous |
| res_valid | input | 1 | One-cycle strobe marking a new result |
| res_raw | input | 16 | Raw straight-binary conversion result |
| bus_q | output | 16 | Data bus value, zero where not enabled |
| bus_oe | output | 16 | Per-pin output enable for bus_q |

## Verification
A new result can arrive in the same cycle that a host read is in progress, whether the read is parallel or serial. The bench provokes this by pulsing res_valid while cs_n and rd_n are held low, with the swap and coding inputs also being changed mid-read. It judges the outcome by comparing the bus every clock against a behavioural model. That model keeps the parked word apart from the visible one and releases it only on a deselected cycle. A following read must then show the new word, coded with the value twos_sel had when that read began.

// File: rtl/adc_result_port.sv
module adc_result_port #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         ser_mode,
  input  logic         swap_bytes,
  input  logic         twos_sel,
  input  logic         sclk,
  input  logic         res_valid,
  input  logic [W-1:0] res_raw,
  output logic [W-1:0] bus_q,
  output logic [W-1:0] bus_oe
);
  localparam int HALF = W / 2;
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic         sel;
  logic [W-1:0] pend_word, vis_word, coded, swapped;
  logic         pend, twos_q, sfall, sbit;
  logic [2:0]   sclk_pipe;
  logic [CW-1:0] cnt;

  assign sel = ~(cs_n | rd_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_word <= '0;
      pend      <= 1'b0;
      vis_word  <= '0;
    end else begin
      if (!sel && pend) begin
        vis_word <= pend_word;
        pend     <= 1'b0;
      end
      if (res_valid) begin
        pend_word <= res_raw;
        pend      <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      twos_q    <= 1'b0;
      sclk_pipe <= '0;
      cnt       <= '0;
    end else begin
      sclk_pipe <= {sclk_pipe[1:0], sclk};
      if (!sel) begin
        twos_q <= twos_sel;
        cnt    <= '0;
      end else if (sfall && cnt != LAST) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign sfall   = sclk_pipe[2] & ~sclk_pipe[1];
  assign coded   = vis_word ^ {twos_q, {(W-1){1'b0}}};
  assign swapped = {coded[HALF-1:0], coded[W-1:HALF]};
  assign sbit    = coded[LAST - cnt];

  assign bus_oe = !sel ? '0 : (ser_mode ? W'(1) : '1);
  assign bus_q  = !sel ? '0 :
                  ser_mode ? {{(W-1){1'b0}}, sbit} :
                  (swap_bytes ? swapped : coded);
endmodule

module adc_result_port_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_n,
  input logic         rd_n,
  input logic         ser_mode,
  input logic         swap_bytes,
  input logic [W-1:0] bus_q,
  input logic [W-1:0] bus_oe
);
  // R2
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> (bus_oe == '0 && bus_q == '0));
  // R3
  par_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_n && !ser_mode) |-> (bus_oe == '1));
  // R8
  ser_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_n && ser_mode) |-> (bus_oe == W'(1) && bus_q[W-1:1] == '0));
  // R7
  par_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_n && !ser_mode && !$past(cs_n) && !$past(rd_n) &&
     !$past(ser_mode) && swap_bytes == $past(swap_bytes)) |-> (bus_q == $past(bus_q)));
endmodule

bind adc_result_port adc_result_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .ser_mode(ser_mode),
  .swap_bytes(swap_bytes), .bus_q(bus_q), .bus_oe(bus_oe)
);

// File: tb/test_adc_result_port.sv
module test_adc_result_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, ser_mode = 1'b0, swap_bytes = 1'b0;
  logic twos_sel = 1'b0, sclk = 1'b0, res_valid = 1'b0;
  logic [15:0] res_raw = '0;
  logic [15:0] bus_q, bus_oe;

  adc_result_port #(.W(16)) i_adc_result_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .ser_mode(ser_mode),
    .swap_bytes(swap_bytes), .twos_sel(twos_sel), .sclk(sclk),
    .res_valid(res_valid), .res_raw(res_raw), .bus_q(bus_q), .bus_oe(bus_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0, mismatched = 0, settle = 0;
  bit done = 1'b0;
  string cur_req = "R1";
  logic [15:0] m_vis = '0, m_pw = '0;
  bit m_pend = 1'b0, m_twos = 1'b0;
  int m_cnt = 0;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_vis = '0; m_pw = '0; m_pend = 1'b0; m_twos = 1'b0; m_cnt = 0;
    end else begin
      bit s, np;
      s = !(cs_n || rd_n);
      np = m_pend;
      if (!s && m_pend) begin m_vis = m_pw; np = 1'b0; end
      if (res_valid) begin m_pw = res_raw; np = 1'b1; end
      m_pend = np;
      if (!s) begin m_twos = twos_sel; m_cnt = 0; end
    end
    if (settle > 0) settle--;
  end

  function automatic logic [15:0] coded_word();
    return m_vis ^ {m_twos, 15'b0};
  endfunction

  always @(posedge clk) begin
    #2;
    if (cs_n || rd_n) begin
      chk(cur_req, bus_oe, 16'h0000);
      chk(cur_req, bus_q, 16'h0000);
    end else if (!ser_mode) begin
      logic [15:0] c;
      c = coded_word();
      chk(cur_req, bus_oe, 16'hFFFF);
      chk(cur_req, bus_q, swap_bytes ? {c[7:0], c[15:8]} : c);
    end else begin
      logic [15:0] c;
      c = coded_word();
      chk(cur_req, bus_oe, 16'h0001);
      if (settle == 0) chk(cur_req, bus_q, {15'b0, c[15 - m_cnt]});
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(logic [15:0] w);
    @(negedge clk); res_raw = w; res_valid = 1'b1;
    @(negedge clk); res_valid = 1'b0;
  endtask

  task automatic sel_on();
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
  endtask

  task automatic sel_off();
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic spulse();
    @(negedge clk); sclk = 1'b1;
    cyc(4); sclk = 1'b0; settle = 3;
    if (!(cs_n || rd_n) && m_cnt < 15) m_cnt++;
    cyc(4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    cyc(3);
    #1 chk("R1", bus_oe, 16'h0000);
    rst_n = 1'b1;
    sel_on(); cyc(1);
    #1 chk("R1", bus_q, 16'h0000);
    sel_off(); cyc(1);

    cur_req = "R6";
    push(16'h1234); cyc(1);
    cur_req = "R3";
    sel_on(); cyc(1);
    #1 chk("R3", bus_q, 16'h1234);
    cur_req = "R4";
    @(negedge clk) swap_bytes = 1'b1; cyc(1);
    #1 chk("R4", bus_q, 16'h3412);
    @(negedge clk) swap_bytes = 1'b0;
    cur_req = "R2";
    @(negedge clk) cs_n = 1'b1; cyc(1);
    #1 chk("R2", bus_oe, 16'h0000);
    @(negedge clk) cs_n = 1'b0; rd_n = 1'b1; cyc(1);
    #1 chk("R2", bus_q, 16'h0000);
    sel_off(); cyc(1);

    cur_req = "R5";
    @(negedge clk) twos_sel = 1'b1;
    push(16'h8001); cyc(1);
    sel_on(); cyc(1);
    #1 chk("R5", bus_q, 16'h0001);
    sel_off();
    push(16'h7FFF); cyc(1);
    sel_on(); cyc(1);
    #1 chk("R5", bus_q, 16'hFFFF);
    sel_off(); @(negedge clk) twos_sel = 1'b0; cyc(1);

    cur_req = "R7";
    push(16'h1234); cyc(1);
    sel_on();
    push(16'hBEEF);
    @(negedge clk) swap_bytes = 1'b1; cyc(2);
    #1 chk("R7", bus_q, 16'h3412);
    @(negedge clk) swap_bytes = 1'b0;
    sel_off(); cyc(1);
    sel_on(); cyc(1);
    #1 chk("R7", bus_q, 16'hBEEF);

    cur_req = "R10";
    @(negedge clk) twos_sel = 1'b1; cyc(2);
    #1 chk("R10", bus_q, 16'hBEEF);
    sel_off(); cyc(1);
    sel_on(); cyc(1);
    #1 chk("R10", bus_q, 16'h3EEF);
    sel_off(); @(negedge clk) twos_sel = 1'b0; cyc(1);

    cur_req = "R8";
    push(16'hA5C3); cyc(1);
    @(negedge clk) ser_mode = 1'b1;
    sel_on(); cyc(2);
    push(16'h0F0F);
    for (int i = 0; i < 16; i++) begin
      #1 chk("R8", {15'b0, bus_q[0]}, {15'b0, 1'(16'hA5C3 >> (15 - (i > 15 ? 15 : i)))});
      spulse();
    end
    cur_req = "R9";
    #1 chk("R9", {15'b0, bus_q[0]}, 16'h0001);
    spulse(); spulse();
    #1 chk("R9", {15'b0, bus_q[0]}, 16'h0001);
    sel_off(); cyc(1);
    sel_on(); cyc(2);
    #1 chk("R9", {15'b0, bus_q[0]}, 16'h0000);
    spulse();
    #1 chk("R8", {15'b0, bus_q[0]}, 16'h0000);
    spulse(); spulse(); spulse();
    #1 chk("R8", {15'b0, bus_q[0]}, 16'h0001);
    sel_off(); @(negedge clk) ser_mode = 1'b0; cyc(3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule